// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block judges a memory access whose address translation is already complete. It receives the domain number of the mapping, the permission fields of the descriptor, the size class of the mapping and the attributes of the access: privileged or user, read or write. It reads the domain control word to find how that domain is treated, picks the permission field that covers the accessed address, and returns one verdict: allow, domain fault or permission fault.

The check is a single registered stage. A request presented with `in_valid` produces its verdict with `out_valid` on the next clock edge. A new request may be presented on every cycle. The domain control word is an input, so the register that holds it stays outside the block.

Top module: `dom_perm_check`

## Requirements
- R1: The access class of domain d is read from bits [2d+1:2d] of `dacr`. `dom_id` selects d.
- R2: Domain class 2'b00 (blocked) produces a domain fault whatever the permission field holds.
- R3: Domain class 2'b10 (reserved) also produces a domain fault.
- R4: Domain class 2'b11 (unchecked) allows every access and skips the permission field.
- R5: Domain class 2'b01 (checked), privileged access: permission 2'b00 allows reads and gives a permission fault on writes. Permissions 2'b01, 2'b10 and 2'b11 allow both reads and writes.
- R6: Domain class 2'b01, user access: permissions 2'b00 and 2'b01 give a permission fault. Permission 2'b10 allows reads and faults writes. Permission 2'b11 allows both.
- R7: `ap_fields` holds four subpage fields. Field i sits at bits [2i+1:2i]. For `kind` 2'b01 (64 KB page), i comes from `va_hi_idx` (address bits 15:14), and `va_lo_idx` has no effect.
- R8: For `kind` 2'b10 (4 KB page), i comes from `va_lo_idx` (address bits 11:10), and `va_hi_idx` has no effect.
- R9: For `kind` 2'b11 (1 KB page), field 0 is always used. For `kind` 2'b00 (section), field 3 is always used.
- R10: Each request with `in_valid` high produces a verdict with `out_valid` high one cycle later. In that verdict exactly one of `allow`, `dom_fault` and `perm_fault` is high, and a domain fault takes priority over a permission fault. When `out_valid` is low, all three verdict outputs are low.
- R11: A synchronous active-high `rst` clears `out_valid` and all verdict outputs on the next edge, even if a request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| priv | input | 1 | 1 = privileged access, 0 = user access |
| wr | input | 1 | 1 = write, 0 = read |
| kind | input | 2 | Mapping size: 00 section, 01 64 KB, 10 4 KB, 11 1 KB |
| dom_id | input | 4 | Domain number of the mapping |
| ap_fields | input | 8 | Four 2-bit permission fields, field i at [2i+1:2i] |
| va_hi_idx | input | 2 | Address bits 15:14 |
| va_lo_idx | input | 2 | Address bits 11:10 |
| dacr | input | 32 | Domain control word, two bits per domain |
| out_valid | output | 1 | Verdict present |
| allow | output | 1 | Access permitted |
| dom_fault | output | 1 | Access refused by the domain class |
| perm_fault | output | 1 | Access refused by the permission field |

## Verification
The domain override and the permission decode act in the same cycle. A request can therefore fail both tests at once. The bench provokes this with a user write to a blocked domain whose selected field is 2'b00, which would also be a permission violation, and expects only `dom_fault`. The reverse case is also driven: an unchecked domain with a field that forbids the access must give `allow` alone. Back-to-back requests with different domains show that no verdict leaks into the next cycle.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    localparam int AP_W  = 2;
    localparam int SUB_N = 4;

    typedef enum logic [1:0] {
        DM_BLOCKED = 2'b00,
        DM_CHECKED = 2'b01,
        DM_RSVD    = 2'b10,
        DM_OPEN    = 2'b11
    } dom_mode_e;

    typedef enum logic [1:0] {
        PG_SECTION = 2'b00,
        PG_LARGE   = 2'b01,
        PG_SMALL   = 2'b10,
        PG_TINY    = 2'b11
    } pg_kind_e;

    typedef struct packed {
        logic allow;
        logic dom_fault;
        logic perm_fault;
    } verdict_t;

    // Permission field decode for a checked domain.
    function automatic logic ap_grants(logic [AP_W-1:0] ap, logic is_priv, logic is_wr);
        logic ok;
        if (is_priv) begin
            ok = !(is_wr && ap == 2'b00);
        end else begin
            case (ap)
                2'b11:   ok = 1'b1;
                2'b10:   ok = !is_wr;
                default: ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

    // Domain class first, permission field second.
    function automatic verdict_t judge(dom_mode_e mode, logic grant);
        verdict_t v;
        v = '0;
        case (mode)
            DM_OPEN:    v.allow = 1'b1;
            DM_CHECKED: begin
                v.allow      = grant;
                v.perm_fault = !grant;
            end
            default:    v.dom_fault = 1'b1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dpc_dom_lookup.sv
module dpc_dom_lookup
    import dpc_pkg::*;
#(
    parameter int NUM_DOM = 16,
    localparam int IDX_W  = $clog2(NUM_DOM)
) (
    input  logic [2*NUM_DOM-1:0] ctrl,
    input  logic [IDX_W-1:0]     idx,
    output dom_mode_e            mode
);

    logic [1:0] slot [NUM_DOM];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_slot
        assign slot[g] = ctrl[2*g+1 : 2*g];
    end

    assign mode = dom_mode_e'(slot[idx]);

endmodule

// File: rtl/dpc_ap_pick.sv
module dpc_ap_pick
    import dpc_pkg::*;
#(
    parameter int SUBS    = SUB_N,
    localparam int SEL_W  = $clog2(SUBS),
    localparam int FLD_W  = AP_W * SUBS
) (
    input  pg_kind_e           kind,
    input  logic [FLD_W-1:0]   fields,
    input  logic [SEL_W-1:0]   hi_sel,
    input  logic [SEL_W-1:0]   lo_sel,
    output logic [AP_W-1:0]    ap
);

    logic [AP_W-1:0] sub [SUBS];

    for (genvar g = 0; g < SUBS; g++) begin : g_sub
        assign sub[g] = fields[AP_W*g +: AP_W];
    end

    always_comb begin
        unique case (kind)
            PG_LARGE:   ap = sub[hi_sel];
            PG_SMALL:   ap = sub[lo_sel];
            PG_TINY:    ap = sub[0];
            default:    ap = sub[SUBS-1];
        endcase
    end

endmodule

// File: rtl/dom_perm_check.sv
module dom_perm_check
    import dpc_pkg::*;
#(
    parameter int NUM_DOM = 16,
    localparam int IDX_W  = $clog2(NUM_DOM),
    localparam int SEL_W  = $clog2(SUB_N),
    localparam int FLD_W  = AP_W * SUB_N
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 priv,
    input  logic                 wr,
    input  logic [1:0]           kind,
    input  logic [IDX_W-1:0]     dom_id,
    input  logic [FLD_W-1:0]     ap_fields,
    input  logic [SEL_W-1:0]     va_hi_idx,
    input  logic [SEL_W-1:0]     va_lo_idx,
    input  logic [2*NUM_DOM-1:0] dacr,
    output logic                 out_valid,
    output logic                 allow,
    output logic                 dom_fault,
    output logic                 perm_fault
);

    dom_mode_e       dom_mode;
    logic [AP_W-1:0] ap_sel;
    verdict_t        next_v;
    verdict_t        held_v;

    dpc_dom_lookup #(.NUM_DOM(NUM_DOM)) u_dom (
        .ctrl (dacr),
        .idx  (dom_id),
        .mode (dom_mode)
    );

    dpc_ap_pick #(.SUBS(SUB_N)) u_pick (
        .kind   (pg_kind_e'(kind)),
        .fields (ap_fields),
        .hi_sel (va_hi_idx),
        .lo_sel (va_lo_idx),
        .ap     (ap_sel)
    );

    assign next_v = judge(dom_mode, ap_grants(ap_sel, priv, wr));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            held_v    <= '0;
        end else begin
            out_valid <= in_valid;
            held_v    <= in_valid ? next_v : '0;
        end
    end

    assign allow      = held_v.allow;
    assign dom_fault  = held_v.dom_fault;
    assign perm_fault = held_v.perm_fault;

    // Verdict framing
    assert_single_verdict_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones({allow, dom_fault, perm_fault}) == 1);
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(allow || dom_fault || perm_fault));
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> !out_valid && !allow && !dom_fault && !perm_fault);

    // Domain override against the looked-up class (R3 shares this check)
    assert_dom_block_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && !dom_mode[0] |=> dom_fault);
    assert_open_domain_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && dom_mode == DM_OPEN |=> allow);

    // Permission decode against the picked field
    assert_priv_read_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && dom_mode == DM_CHECKED && priv && !wr |=> allow);
    assert_user_write_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && dom_mode == DM_CHECKED && !priv && wr && ap_sel != 2'b11 |=> perm_fault);

endmodule

// File: tb/sim_dom_perm_check.sv
module sim_dom_perm_check;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        priv;
    logic        wr;
    logic [1:0]  kind;
    logic [3:0]  dom_id;
    logic [7:0]  ap_fields;
    logic [1:0]  va_hi_idx;
    logic [1:0]  va_lo_idx;
    logic [31:0] dacr;
    logic        out_valid, allow, dom_fault, perm_fault;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dom_perm_check u0 (
        .clk, .rst, .in_valid, .priv, .wr, .kind, .dom_id, .ap_fields,
        .va_hi_idx, .va_lo_idx, .dacr,
        .out_valid, .allow, .dom_fault, .perm_fault
    );

    // d0 checked, d1 open, d2 blocked, d3 reserved, d7 open, d15 checked, rest blocked
    localparam logic [31:0] CTRL_A = 32'h4000_C08D;

    // exp: {allow, dom_fault, perm_fault}
    typedef struct packed {
        logic       p;
        logic       w;
        logic [1:0] k;
        logic [3:0] d;
        logic [7:0] ap;
        logic [1:0] hi;
        logic [1:0] lo;
        logic [2:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 2'b00, 4'd0,  8'hE4, 2'd0, 2'd0, 3'b100, 4'd9},  // R9 section uses field 3
        '{1'b1, 1'b1, 2'b00, 4'd0,  8'h3F, 2'd0, 2'd0, 3'b001, 4'd5},  // R5 priv write under 00
        '{1'b0, 1'b0, 2'b11, 4'd0,  8'hE4, 2'd3, 2'd3, 3'b001, 4'd9},  // R9 tiny uses field 0
        '{1'b0, 1'b1, 2'b11, 4'd0,  8'h03, 2'd2, 2'd1, 3'b100, 4'd6},  // R6 user write under 11
        '{1'b1, 1'b0, 2'b01, 4'd0,  8'hE4, 2'd0, 2'd3, 3'b100, 4'd7},  // R7 large idx0
        '{1'b0, 1'b0, 2'b01, 4'd0,  8'hE4, 2'd1, 2'd0, 3'b001, 4'd7},  // R7 large idx1 user read 01
        '{1'b0, 1'b0, 2'b01, 4'd0,  8'hE4, 2'd2, 2'd0, 3'b100, 4'd7},  // R7 large idx2
        '{1'b0, 1'b1, 2'b01, 4'd0,  8'hE4, 2'd3, 2'd0, 3'b100, 4'd7},  // R7 large idx3
        '{1'b0, 1'b1, 2'b01, 4'd0,  8'hE4, 2'd2, 2'd3, 3'b001, 4'd7},  // R7 lo index ignored
        '{1'b0, 1'b1, 2'b10, 4'd0,  8'hE4, 2'd0, 2'd2, 3'b001, 4'd8},  // R8 small idx2 user write
        '{1'b0, 1'b0, 2'b10, 4'd0,  8'hE4, 2'd0, 2'd2, 3'b100, 4'd8},  // R8 small idx2 user read
        '{1'b0, 1'b0, 2'b10, 4'd0,  8'hE4, 2'd3, 2'd1, 3'b001, 4'd8},  // R8 small idx1 user read
        '{1'b1, 1'b1, 2'b10, 4'd0,  8'hE4, 2'd3, 2'd1, 3'b100, 4'd5},  // R5 priv write under 01
        '{1'b0, 1'b1, 2'b10, 4'd0,  8'hE4, 2'd0, 2'd3, 3'b100, 4'd8},  // R8 small idx3
        '{1'b1, 1'b1, 2'b10, 4'd0,  8'hE4, 2'd3, 2'd0, 3'b001, 4'd8},  // R8 hi index ignored
        '{1'b0, 1'b1, 2'b00, 4'd1,  8'h00, 2'd0, 2'd0, 3'b100, 4'd4},  // R4 open domain
        '{1'b1, 1'b0, 2'b00, 4'd2,  8'hFF, 2'd0, 2'd0, 3'b010, 4'd2},  // R2 blocked domain
        '{1'b1, 1'b0, 2'b00, 4'd3,  8'hFF, 2'd0, 2'd0, 3'b010, 4'd3},  // R3 reserved domain
        '{1'b0, 1'b1, 2'b00, 4'd15, 8'h00, 2'd0, 2'd0, 3'b001, 4'd1},  // R1 top domain slot
        '{1'b0, 1'b1, 2'b00, 4'd7,  8'h00, 2'd0, 2'd0, 3'b100, 4'd1},  // R1 middle slot
        '{1'b1, 1'b0, 2'b00, 4'd4,  8'hFF, 2'd0, 2'd0, 3'b010, 4'd1},  // R1 zeroed slot
        '{1'b1, 1'b1, 2'b00, 4'd0,  8'h40, 2'd0, 2'd0, 3'b100, 4'd5},  // R5 priv write under 01
        '{1'b1, 1'b1, 2'b00, 4'd0,  8'h80, 2'd0, 2'd0, 3'b100, 4'd5},  // R5 priv write under 10
        '{1'b0, 1'b1, 2'b00, 4'd0,  8'h80, 2'd0, 2'd0, 3'b001, 4'd6}   // R6 user write under 10
    };

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: {out_valid,allow,dom_fault,perm_fault} got %b expected %b", req, got, exp);
        end
    endtask

    task automatic put(input logic p, input logic w, input logic [1:0] k, input logic [3:0] d,
                       input logic [7:0] ap, input logic [1:0] hi, input logic [1:0] lo,
                       input logic [31:0] ctl);
        in_valid  = 1'b1;
        priv      = p;
        wr        = w;
        kind      = k;
        dom_id    = d;
        ap_fields = ap;
        va_hi_idx = hi;
        va_lo_idx = lo;
        dacr      = ctl;
    endtask

    function automatic logic [3:0] outs();
        return {out_valid, allow, dom_fault, perm_fault};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; priv = 1'b0; wr = 1'b0; kind = 2'b00; dom_id = '0;
        ap_fields = '0; va_hi_idx = '0; va_lo_idx = '0; dacr = '0;
        repeat (3) @(negedge clk);
        check("R11 reset state", outs(), 4'b0000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            put(VECS[i].p, VECS[i].w, VECS[i].k, VECS[i].d, VECS[i].ap, VECS[i].hi, VECS[i].lo, CTRL_A);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vector %0d", VECS[i].req, i), outs(), {1'b1, VECS[i].exp});
        end

        // R10 idle cycle clears the verdict
        @(negedge clk);
        check("R10 idle after verdict", outs(), 4'b0000);

        // R10 priority: blocked domain and a forbidding field at once
        put(1'b0, 1'b1, 2'b10, 4'd2, 8'h00, 2'd0, 2'd0, CTRL_A);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 domain fault wins", outs(), 4'b1010);

        // R4 open domain overrides a forbidding field
        put(1'b0, 1'b1, 2'b01, 4'd9, 8'h00, 2'd1, 2'd0, 32'hFFFF_FFFF);
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 all-open control word", outs(), 4'b1100);

        // R10 back-to-back requests keep their own verdicts
        put(1'b1, 1'b1, 2'b00, 4'd1, 8'h00, 2'd0, 2'd0, CTRL_A);
        @(negedge clk);
        check("R10 first of pair", outs(), 4'b1100);
        put(1'b1, 1'b0, 2'b00, 4'd3, 8'hFF, 2'd0, 2'd0, CTRL_A);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 second of pair", outs(), 4'b1010);
        @(negedge clk);
        check("R10 idle after pair", outs(), 4'b0000);

        // R11 reset wins over a live request
        put(1'b1, 1'b0, 2'b00, 4'd1, 8'hFF, 2'd0, 2'd0, CTRL_A);
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        check("R11 reset with request", outs(), 4'b0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule